// File: doc/BRIEF.md
# Multicycle 32-bit Processor Core with Step Sequencer

This block is a small 32-bit processor core. It runs a nine-instruction subset: word load, word store, the register-register operations add, subtract, and, or and set-less-than, branch-if-equal, and an absolute jump. It time-shares one memory port and one ALU across several clock cycles. A Moore state machine moves each instruction through a fetch step, a decode step and then one to three further steps. A branch or jump takes three cycles, a store or register operation takes four, and a load takes five.

Holding registers carry values from one step to the next. These are the instruction register, the memory-data register, the two operand registers and the ALU-result register. The same ALU increments the program counter during fetch. During decode it computes a candidate branch target ahead of knowing the opcode. The core drives a single memory bus that serves both instruction fetch and data access. Memory read data must be returned combinationally in the same cycle.

The current step number and a one-cycle completion pulse are brought out so that an environment can trace the sequencing of each instruction.

Top module: `stepped_cpu`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `step_state` is 0 (fetch), `mem_rd` is 1, `mem_wr` is 0 and `mem_addr` is 0.
- R2: Opcode bits [31:26] select the instruction class, with this timing from fetch to completion. Load (0x23) takes 5 cycles. Store (0x2B) takes 4 cycles. Register operation (0x00) takes 4 cycles. Branch-if-equal (0x04) takes 3 cycles. Jump (0x02) takes 3 cycles. `instr_done` is high only in the last of those cycles, and the next cycle is a fetch.
- R3: `step_state` uses these codes: 0 fetch, 1 decode, 2 address, 3 load-read, 4 load-writeback, 5 store-write, 6 register-execute, 7 register-writeback, 8 branch-execute, 9 jump-execute. A fetch is always followed by a decode.
- R4: A register operation reads rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11). Function bits [5:0] choose the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A set-less-than. Set-less-than compares as signed numbers and gives 1 or 0.
- R5: A load reads the word at rs plus the sign-extended bits 15:0 and writes it to register rt.
- R6: A store drives register rt onto `mem_wdata` at address rs plus the sign-extended offset. It asserts `mem_wr` for exactly one cycle, and only in step 5. `mem_rd` and `mem_wr` are never high together.
- R7: Branch-if-equal compares rs and rt. When they are equal, the next fetch address is the branch's address + 4 + (sign-extended offset × 4). Otherwise it is the branch's address + 4.
- R8: A jump sets the next fetch address to bits 31:28 of (its address + 4), then bits 25:0 of the instruction, then two zero bits.
- R9: Register 0 always reads as zero, and any write to it is ignored.
- R10: An instruction with any other opcode returns from decode to fetch without writing a register or memory and without an `instr_done` pulse. The following fetch uses its address + 4.
- R11: The program counter changes only at the end of a fetch, branch-execute or jump-execute step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| step_state | output | 4 | Current step code (see R3) |
| instr_done | output | 1 | High in the final cycle of each recognised instruction |

## Verification
In the branch-execute step, the ALU subtraction that decides the branch and the program-counter load from the precomputed target happen in the same cycle. The program-counter write is gated by that cycle's zero flag. The test program exercises this with a branch that is not taken, a forward taken branch over stores that would leave marks if executed, and a taken backward branch to itself. Each case is judged by comparing every fetch address against an expected sequence, and by checking that the skipped stores never appear on the bus.

// File: rtl/stepped_cpu_pkg.sv
package stepped_cpu_pkg;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_LDRD   = 4'd3,
      ST_LDWB   = 4'd4,
      ST_STWR   = 4'd5,
      ST_REXE   = 4'd6,
      ST_RWB    = 4'd7,
      ST_BRX    = 4'd8,
      ST_JMPX   = 4'd9
   } step_e;

   localparam logic [5:0] OP_REG  = 6'h00;
   localparam logic [5:0] OP_JMP  = 6'h02;
   localparam logic [5:0] OP_BEQ  = 6'h04;
   localparam logic [5:0] OP_LOAD = 6'h23;
   localparam logic [5:0] OP_STOR = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [1:0] {
      AOP_ADD   = 2'd0,
      AOP_SUB   = 2'd1,
      AOP_FUNCT = 2'd2
   } aluop_e;

   // operand B choices
   localparam logic [1:0] SB_REG  = 2'd0;
   localparam logic [1:0] SB_FOUR = 2'd1;
   localparam logic [1:0] SB_IMM  = 2'd2;
   localparam logic [1:0] SB_IMM4 = 2'd3;

   // next-PC choices
   localparam logic [1:0] PS_ALU  = 2'd0;
   localparam logic [1:0] PS_HOLD = 2'd1;
   localparam logic [1:0] PS_JUMP = 2'd2;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       use_data_addr;
      logic       mem_rd;
      logic       mem_wr;
      logic       ir_wr;
      logic       wb_from_mem;
      logic       wb_to_rd;
      logic       reg_wr;
      logic       a_from_reg;
      logic [1:0] b_sel;
      aluop_e     alu_op;
      logic [1:0] pc_sel;
   } ctrl_t;

endpackage

// File: rtl/stepped_ctrl.sv
module stepped_ctrl
   import stepped_cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   output step_e      state,
   output ctrl_t      ctl,
   output logic       done
);

   step_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      nxt = ST_FETCH;
      unique case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OP_LOAD, OP_STOR: nxt = ST_ADDR;
               OP_REG:           nxt = ST_REXE;
               OP_BEQ:           nxt = ST_BRX;
               OP_JMP:           nxt = ST_JMPX;
               default:          nxt = ST_FETCH;
            endcase
         end
         ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_LDRD : ST_STWR;
         ST_LDRD:   nxt = ST_LDWB;
         ST_REXE:   nxt = ST_RWB;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl = '0;
      ctl.alu_op = AOP_ADD;
      done = 1'b0;
      unique case (state)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_wr  = 1'b1;
            ctl.b_sel  = SB_FOUR;
            ctl.pc_wr  = 1'b1;
            ctl.pc_sel = PS_ALU;
         end
         ST_DECODE: ctl.b_sel = SB_IMM4;
         ST_ADDR: begin
            ctl.a_from_reg = 1'b1;
            ctl.b_sel      = SB_IMM;
         end
         ST_LDRD: begin
            ctl.mem_rd        = 1'b1;
            ctl.use_data_addr = 1'b1;
         end
         ST_LDWB: begin
            ctl.reg_wr      = 1'b1;
            ctl.wb_from_mem = 1'b1;
            done            = 1'b1;
         end
         ST_STWR: begin
            ctl.mem_wr        = 1'b1;
            ctl.use_data_addr = 1'b1;
            done              = 1'b1;
         end
         ST_REXE: begin
            ctl.a_from_reg = 1'b1;
            ctl.b_sel      = SB_REG;
            ctl.alu_op     = AOP_FUNCT;
         end
         ST_RWB: begin
            ctl.reg_wr   = 1'b1;
            ctl.wb_to_rd = 1'b1;
            done         = 1'b1;
         end
         ST_BRX: begin
            ctl.a_from_reg = 1'b1;
            ctl.b_sel      = SB_REG;
            ctl.alu_op     = AOP_SUB;
            ctl.pc_wr_cond = 1'b1;
            ctl.pc_sel     = PS_HOLD;
            done           = 1'b1;
         end
         ST_JMPX: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_sel = PS_JUMP;
            done       = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/stepped_alu.sv
module stepped_alu
   import stepped_cpu_pkg::*;
#(
   parameter int W          = 32,
   parameter bit SLT_SIGNED = 1'b1
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  aluop_e       op,
   input  logic [5:0]   funct,
   output logic [W-1:0] y,
   output logic         zero
);

   logic lt;

   generate
      if (SLT_SIGNED) begin : g_lt_s
         assign lt = $signed(a) < $signed(b);
      end else begin : g_lt_u
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      y = a + b;
      if (op == AOP_SUB) begin
         y = a - b;
      end else if (op == AOP_FUNCT) begin
         case (funct)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
         endcase
      end
   end

   assign zero = (y == '0);

endmodule

// File: rtl/stepped_regfile.sv
module stepped_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(NREGS)-1:0] ra1,
   input  logic [$clog2(NREGS)-1:0] ra2,
   input  logic                     we,
   input  logic [$clog2(NREGS)-1:0] wa,
   input  logic [W-1:0]             wd,
   output logic [W-1:0]             rd1,
   output logic [W-1:0]             rd2
);

   logic [W-1:0] regs [NREGS];

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign regs[i] = '0;
         end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                  regs[i] <= '0;
               else if (we && wa == i[$clog2(NREGS)-1:0]) regs[i] <= wd;
            end
         end
      end
   endgenerate

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];

endmodule

// File: rtl/stepped_cpu.sv
module stepped_cpu
   import stepped_cpu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREGS      = 32,
   parameter bit SLT_SIGNED = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [3:0]      step_state,
   output logic            instr_done
);

   localparam int RAW = $clog2(NREGS);
   localparam int IMMW = 16;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("stepped_cpu: XLEN must be 32");
      end
      if (NREGS != 32) begin : g_bad_nregs
         $error("stepped_cpu: NREGS must be 32");
      end
   endgenerate

   step_e state;
   ctrl_t ctl;

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
   logic [XLEN-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, sext, pc_next, wb_data;
   logic            alu_zero, pc_load;
   logic [RAW-1:0]  wb_addr;

   stepped_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir_q[31:26]),
      .state  (state),
      .ctl    (ctl),
      .done   (instr_done)
   );

   assign sext = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};

   always_comb begin
      unique case (ctl.b_sel)
         SB_REG:  alu_b = b_q;
         SB_FOUR: alu_b = XLEN'(4);
         SB_IMM:  alu_b = sext;
         default: alu_b = {sext[XLEN-3:0], 2'b00};
      endcase
   end
   assign alu_a = ctl.a_from_reg ? a_q : pc_q;

   stepped_alu #(.W(XLEN), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .a     (alu_a),
      .b     (alu_b),
      .op    (ctl.alu_op),
      .funct (ir_q[5:0]),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   assign wb_addr = ctl.wb_to_rd ? ir_q[15:11] : ir_q[20:16];
   assign wb_data = ctl.wb_from_mem ? mdr_q : aluout_q;

   stepped_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (ir_q[25:21]),
      .ra2   (ir_q[20:16]),
      .we    (ctl.reg_wr),
      .wa    (wb_addr),
      .wd    (wb_data),
      .rd1   (rf_rd1),
      .rd2   (rf_rd2)
   );

   always_comb begin
      unique case (ctl.pc_sel)
         PS_HOLD: pc_next = aluout_q;
         PS_JUMP: pc_next = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
         default: pc_next = alu_y;
      endcase
   end
   assign pc_load = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         ir_q     <= '0;
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         if (pc_load)    pc_q <= pc_next;
         if (ctl.ir_wr)  ir_q <= mem_rdata;
         mdr_q    <= mem_rdata;
         a_q      <= rf_rd1;
         b_q      <= rf_rd2;
         aluout_q <= alu_y;
      end
   end

   assign mem_addr   = ctl.use_data_addr ? aluout_q : pc_q;
   assign mem_wdata  = b_q;
   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign step_state = state;

endmodule

// File: rtl/stepped_cpu_chk.sv
module stepped_cpu_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  state,
   input logic [31:0] pc,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic        done
);

   // R6
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R6
   wr_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (state == 4'd5));

   // R2
   done_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state == 4'd0));

   // R3
   fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'd0) |=> (state == 4'd1));

   // R2
   load_read_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'd3) |=> (state == 4'd4));

   // R11
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 4'd0 && state != 4'd8 && state != 4'd9) |=> $stable(pc));

endmodule

bind stepped_cpu stepped_cpu_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .state  (step_state),
   .pc     (pc_q),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .done   (instr_done)
);

// File: tb/stepped_cpu_test.sv
module stepped_cpu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr, instr_done;
   logic [3:0]  step_state;

   always #10 clk = ~clk;   // 50 MHz

   stepped_cpu uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .step_state (step_state),
      .instr_done (instr_done)
   );

   logic [31:0] mem [0:255];
   assign mem_rdata = mem[mem_addr[9:2]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
   endfunction
   function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   // scoreboard queues
   logic [31:0] exp_fetch [$];
   logic [31:0] exp_st_addr [$];
   logic [31:0] exp_st_data [$];
   int          exp_len [$];

   task automatic push_fetch(input int idx);
      exp_fetch.push_back(32'(idx * 4));
   endtask
   task automatic push_store(input logic [31:0] a, input logic [31:0] d);
      exp_st_addr.push_back(a);
      exp_st_data.push_back(d);
   endtask

   // monitor
   int run_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (step_state == 4'd0) run_len = 1;
         else                    run_len = run_len + 1;
         if (step_state == 4'd0 && exp_fetch.size() > 0) begin
            logic [31:0] e;
            e = exp_fetch.pop_front();
            check(mem_addr == e, "R7/R8/R10 fetch address", mem_addr, e);
         end
         if (mem_wr) begin
            if (exp_st_addr.size() > 0) begin
               logic [31:0] ea, ed;
               ea = exp_st_addr.pop_front();
               ed = exp_st_data.pop_front();
               check(mem_addr == ea, "R5/R6 store address", mem_addr, ea);
               check(mem_wdata == ed, "R4/R6/R9 store data", mem_wdata, ed);
            end else begin
               check(1'b0, "R6/R7 unexpected store", mem_addr, 32'h0);
            end
         end
         if (instr_done && exp_len.size() > 0) begin
            int el;
            el = exp_len.pop_front();
            check(run_len == el, "R2 cycle count", 32'(run_len), 32'(el));
         end
      end
   end

   localparam logic [5:0] LW = 6'h23, SW = 6'h2B, BQ = 6'h04;

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      mem[32] = 32'd5;
      mem[33] = 32'd3;
      mem[34] = 32'hFFFF_FFFF;

      mem[0]  = iop(LW, 0, 1, 16'h0080);
      mem[1]  = iop(LW, 0, 2, 16'h0084);
      mem[2]  = rop(1, 2, 3, 6'h20);
      mem[3]  = rop(1, 2, 4, 6'h22);
      mem[4]  = rop(1, 2, 5, 6'h24);
      mem[5]  = rop(1, 2, 6, 6'h25);
      mem[6]  = rop(2, 1, 7, 6'h2A);
      mem[7]  = rop(1, 2, 8, 6'h2A);
      for (int k = 0; k < 6; k++) mem[8+k] = iop(SW, 0, 3+k, 16'(32'h90 + 4*k));
      mem[14] = iop(BQ, 1, 2, 16'd5);
      mem[15] = 32'hFC00_0000;
      mem[16] = rop(1, 1, 0, 6'h20);
      mem[17] = iop(SW, 0, 0, 16'h00A8);
      mem[18] = iop(BQ, 1, 1, 16'd2);
      mem[19] = iop(SW, 0, 1, 16'h00AC);
      mem[20] = iop(SW, 0, 1, 16'h00AC);
      mem[21] = {6'h02, 26'd24};
      mem[22] = iop(SW, 0, 2, 16'h00B0);
      mem[23] = iop(SW, 0, 2, 16'h00B0);
      mem[24] = iop(LW, 0, 9, 16'h0088);
      mem[25] = rop(9, 1, 10, 6'h2A);
      mem[26] = iop(SW, 0, 10, 16'h00B4);
      mem[27] = iop(SW, 0, 9, 16'h00B8);
      mem[28] = iop(BQ, 0, 0, 16'hFFFF);

      // driver: expected fetch order (R7 taken/not taken, R8 jump, R10 skip)
      for (int k = 0; k <= 18; k++) push_fetch(k);
      push_fetch(21);
      for (int k = 24; k <= 28; k++) push_fetch(k);
      push_fetch(28);
      // expected stores: R4 add/sub/and/or/slt, R9 r0, slt signed
      push_store(32'h90, 32'd8);
      push_store(32'h94, 32'd2);
      push_store(32'h98, 32'd1);
      push_store(32'h9C, 32'd7);
      push_store(32'hA0, 32'd1);
      push_store(32'hA4, 32'd0);
      push_store(32'hA8, 32'd0);        // R9
      push_store(32'hB4, 32'd1);
      push_store(32'hB8, 32'hFFFF_FFFF); // R5 loaded value
      // expected lengths (R2); R10 unknown opcode contributes none
      exp_len.push_back(5); exp_len.push_back(5);
      for (int k = 0; k < 6; k++) exp_len.push_back(4);
      for (int k = 0; k < 6; k++) exp_len.push_back(4);
      exp_len.push_back(3);
      exp_len.push_back(4); exp_len.push_back(4);
      exp_len.push_back(3); exp_len.push_back(3);
      exp_len.push_back(5); exp_len.push_back(4);
      exp_len.push_back(4); exp_len.push_back(4);
      exp_len.push_back(3);

      repeat (3) @(negedge clk);
      // R1 reset state
      check(step_state == 4'd0, "R1 state in reset", 32'(step_state), 32'd0);
      check(mem_addr == 32'h0, "R1 address in reset", mem_addr, 32'h0);
      check(mem_rd && !mem_wr, "R1 strobes in reset", {30'h0, mem_rd, mem_wr}, 32'h2);
      rst_n = 1'b1;

      begin
         int cyc = 0;
         while ((exp_fetch.size() != 0 || exp_st_addr.size() != 0 || exp_len.size() != 0) && cyc < 5000) begin
            @(posedge clk);
            cyc++;
         end
         if (cyc >= 5000) check(1'b0, "R2 watchdog expired", 32'(cyc), 32'd5000);
      end
      repeat (20) @(negedge clk);
      check(mem[43] == 32'h0, "R7 skipped store absent", mem[43], 32'h0);
      check(mem[44] == 32'h0, "R8 skipped store absent", mem[44], 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule